// File: doc/BRIEF.md
# Parallel Port Mode Selector and Data FIFO

This block holds the mode control byte of a multimode parallel port and the small data FIFO that sits behind it. A three-bit mode field chooses how the port behaves: plain output, bidirectional byte transfer, a FIFO fed by the host and emptied by a printer-style handshake, a FIFO for the extended-capability handshake, an enhanced mode, a reserved code, a FIFO test mode and a configuration mode. From that field the block derives three enables for the rest of the port. One says whether the standard data, status and control registers respond. One says whether the direction bit may turn the data lines around. One says whether the two configuration registers are reachable.

The host writes the control byte and reads it back. The two low bits of the readback are not stored: they show the FIFO's full and empty state at that moment. In FIFO test mode the host pushes bytes through the test FIFO port and pops them through the same port, so the depth and the flags can be checked from software. In the printer-handshake FIFO mode, a single drain strobe stands in for the handshake engine and takes one byte from the FIFO per cycle.

Top module: `pport_xctl`

## Requirements
- R1: After a synchronous active-low reset the mode field reads 000, bits 4:2 read 0 and the FIFO is empty, so the control readback is 0x01 and the head output is 0.
- R2: A control write stores host bits 7:5 as the mode and bits 4:2 (interrupt, DMA enable, service) as written. Readback is {mode[7:5], bits[4:2], full[1], empty[0]}. Bits 1:0 of a write have no effect.
- R3: In mode 110 a test write pushes the data byte and a test read pops the head. Test writes and reads in any other mode are ignored.
- R4: The full flag is 1 exactly when the FIFO holds FIFO_DEPTH bytes. The empty flag is 1 exactly when it holds none. Both follow the occupancy in the cycle after each push or pop.
- R5: A push into a full FIFO and a pop from an empty FIFO are dropped and leave the contents unchanged. Push and pop rules use the state before the clock edge.
- R6: A data write pushes only in modes 010 and 011. The drain strobe pops one byte per cycle only in mode 010. In mode 000 no FIFO input has any effect.
- R7: The standard-register enable is 0 only in mode 011 and 1 in every other mode.
- R8: The bidirectional enable is 1 only in mode 001.
- R9: The configuration-register enable is 1 only in mode 111.
- R10: Bytes leave the FIFO in the order they entered. The head output shows the oldest byte, or 0 when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wdata | input | 8 | Write data for the control byte and for FIFO pushes |
| xctl_wr | input | 1 | Write strobe for the control byte |
| data_fifo_wr | input | 1 | Host push into the data FIFO (modes 010, 011) |
| test_fifo_wr | input | 1 | Test-port push (mode 110) |
| test_fifo_rd | input | 1 | Test-port pop (mode 110) |
| drain_stb | input | 1 | Handshake stand-in pop (mode 010) |
| xctl_rdata | output | 8 | Control byte readback with live full/empty bits |
| fifo_head | output | 8 | Oldest FIFO byte, 0 when empty |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH bytes |
| fifo_empty | output | 1 | FIFO holds no bytes |
| std_regs_en | output | 1 | Standard port registers respond |
| bidir_en | output | 1 | Direction bit may reverse the data lines |
| cfg_regs_en | output | 1 | Configuration registers A and B reachable |

## Verification
Every result of this block is due one clock after the stimulus that causes it. A control write changes the mode, the readback and the three enables after the next rising edge. A push or pop changes the head byte and the flags after that same edge, and the readback bits 1:0 change at the same time. The bench drives inputs on the falling edge and advances a queue-based model at the rising edge. It then compares every output on the following falling edge, so every stimulus is judged exactly one cycle later.

// File: rtl/pport_xctl_pkg.sv
// Shared types for the parallel port mode selector.
// Assumes the mode codes are fixed by the software that writes bits 7:5.
package pport_xctl_pkg;
    localparam int XW = 8;  // width of the control byte and of FIFO entries

    typedef enum logic [2:0] {
        MODE_STD   = 3'b000,
        MODE_BYTE  = 3'b001,
        MODE_PFIFO = 3'b010,
        MODE_XFIFO = 3'b011,
        MODE_EPP   = 3'b100,
        MODE_RSVD  = 3'b101,
        MODE_TEST  = 3'b110,
        MODE_CFG   = 3'b111
    } xmode_e;
endpackage

// File: rtl/pport_xctl_regs.sv
// Control byte storage and mode decode.
// Holds the mode field and three software flags. Derives the enables for
// the standard registers, the bidirectional path and the configuration
// registers. Assumes a synchronous active-low reset.
module pport_xctl_regs
    import pport_xctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [XW-1:0] wdata,
    output xmode_e        mode,
    output logic [2:0]    flags,
    output logic          std_en,
    output logic          bidir_en,
    output logic          cfg_en
);
    xmode_e     mode_q;
    logic [2:0] flags_q;

    // Store the mode and flag bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_STD;
            flags_q <= '0;
        end else if (wr) begin
            mode_q  <= xmode_e'(wdata[7:5]);
            flags_q <= wdata[4:2];
        end
    end

    // Decode the mode into the enables used elsewhere in the port.
    always_comb begin
        std_en   = (mode_q != MODE_XFIFO);
        bidir_en = (mode_q == MODE_BYTE);
        cfg_en   = (mode_q == MODE_CFG);
    end

    assign mode  = mode_q;
    assign flags = flags_q;

    // R9: a write of code 111 opens the configuration registers next cycle
    assert_cfg_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[7:5] == 3'b111) |=> cfg_en);
    // R8: a write of any code other than 001 closes the bidirectional path
    assert_bidir_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[7:5] != 3'b001) |=> !bidir_en);
    // R2: without a write the stored byte holds
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(mode) && $stable(flags)));
endmodule

// File: rtl/pport_xctl_route.sv
// Routes host and drain strobes to the FIFO push and pop inputs by mode.
// The test port is live only in test mode. The drain strobe is live only
// in the printer-handshake FIFO mode. Data writes feed both FIFO modes.
module pport_xctl_route
    import pport_xctl_pkg::*;
(
    input  xmode_e mode,
    input  logic   data_wr,
    input  logic   test_wr,
    input  logic   test_rd,
    input  logic   drain,
    output logic   push,
    output logic   pop
);
    // Select the push and pop sources for the current mode.
    always_comb begin
        push = 1'b0;
        pop  = 1'b0;
        unique case (mode)
            MODE_TEST:  begin push = test_wr; pop = test_rd; end
            MODE_PFIFO: begin push = data_wr; pop = drain;   end
            MODE_XFIFO: begin push = data_wr;                end
            default:    ;
        endcase
    end
endmodule

// File: rtl/pport_xctl_fifo.sv
// Circular FIFO with occupancy-based full and empty flags.
// Drops a push when full and a pop when empty, using the state before the
// edge. The head reads 0 when empty. DEPTH need not be a power of two.
module pport_xctl_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    // Step a pointer, wrapping after the last entry.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Qualify the requests with the current flags.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // One storage entry per slot, written when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && wr_ptr == PTR_W'(i)) mem[i] <= din;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    // Present the oldest entry, or 0 when nothing is stored.
    assign head = empty ? '0 : mem[rd_ptr];

    // R4: occupancy never exceeds the depth
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R5: a push into a full FIFO without a pop leaves it full
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(rd_ptr)));
    // R5: a pop from an empty FIFO without a push leaves it empty
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (empty && $stable(wr_ptr)));
    // R4: the flags are never both set
    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/pport_xctl.sv
// Top of the parallel port mode selector with its data FIFO.
// Combines the control byte, the strobe routing and the FIFO. The control
// readback carries the live full and empty flags in bits 1:0.
module pport_xctl
    import pport_xctl_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] host_wdata,
    input  logic          xctl_wr,
    input  logic          data_fifo_wr,
    input  logic          test_fifo_wr,
    input  logic          test_fifo_rd,
    input  logic          drain_stb,
    output logic [XW-1:0] xctl_rdata,
    output logic [XW-1:0] fifo_head,
    output logic          fifo_full,
    output logic          fifo_empty,
    output logic          std_regs_en,
    output logic          bidir_en,
    output logic          cfg_regs_en
);
    xmode_e     mode;
    logic [2:0] flags;
    logic       push, pop;

    pport_xctl_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (xctl_wr),
        .wdata    (host_wdata),
        .mode     (mode),
        .flags    (flags),
        .std_en   (std_regs_en),
        .bidir_en (bidir_en),
        .cfg_en   (cfg_regs_en)
    );

    pport_xctl_route i_route (
        .mode    (mode),
        .data_wr (data_fifo_wr),
        .test_wr (test_fifo_wr),
        .test_rd (test_fifo_rd),
        .drain   (drain_stb),
        .push    (push),
        .pop     (pop)
    );

    pport_xctl_fifo #(.W(XW), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (host_wdata),
        .head  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // Assemble the readback from stored fields and live flags.
    assign xctl_rdata = {mode, flags, fifo_full, fifo_empty};

    // R6: in standard mode the FIFO outputs do not move without a mode write
    assert_std_ignores_fifo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STD && !xctl_wr) |=>
            ($stable(fifo_head) && $stable(fifo_full) && $stable(fifo_empty)));
    // R7: selecting the extended FIFO mode hides the standard registers
    assert_std_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xctl_wr && host_wdata[7:5] == 3'b011) |=> !std_regs_en);
endmodule

// File: tb/test_pport_xctl.sv
// Bench: a queue model advanced at each rising edge, compared at each falling edge.
module test_pport_xctl;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       xctl_wr = 1'b0, data_fifo_wr = 1'b0, test_fifo_wr = 1'b0;
    logic       test_fifo_rd = 1'b0, drain_stb = 1'b0;
    logic [7:0] xctl_rdata, fifo_head;
    logic       fifo_full, fifo_empty, std_regs_en, bidir_en, cfg_regs_en;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // model state
    bit [2:0]   m_mode = 3'd0;
    bit [2:0]   m_flags = 3'd0;
    logic [7:0] m_q[$];

    always #5 clk = ~clk;

    pport_xctl #(.FIFO_DEPTH(DEPTH)) i_pport_xctl (
        .clk(clk), .rst_n(rst_n), .host_wdata(host_wdata), .xctl_wr(xctl_wr),
        .data_fifo_wr(data_fifo_wr), .test_fifo_wr(test_fifo_wr),
        .test_fifo_rd(test_fifo_rd), .drain_stb(drain_stb),
        .xctl_rdata(xctl_rdata), .fifo_head(fifo_head), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .std_regs_en(std_regs_en), .bidir_en(bidir_en),
        .cfg_regs_en(cfg_regs_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance the model as the design sees the edge.
    task automatic model_edge();
        bit push_en, pop_en, m_full, m_empty;
        if (!rst_n) begin
            m_mode = 3'd0; m_flags = 3'd0; m_q.delete();
            return;
        end
        push_en = (m_mode == 3'b110) ? test_fifo_wr :
                  (m_mode == 3'b010 || m_mode == 3'b011) ? data_fifo_wr : 1'b0;   // R3 R6
        pop_en  = (m_mode == 3'b110) ? test_fifo_rd :
                  (m_mode == 3'b010) ? drain_stb : 1'b0;
        m_full  = (m_q.size() == DEPTH);
        m_empty = (m_q.size() == 0);
        if (pop_en && !m_empty) void'(m_q.pop_front());                           // R5
        if (push_en && !m_full) m_q.push_back(host_wdata);
        if (xctl_wr) begin m_mode = host_wdata[7:5]; m_flags = host_wdata[4:2]; end // R2
    endtask

    task automatic compare_all();
        bit e_full, e_empty;
        e_full  = (m_q.size() == DEPTH);
        e_empty = (m_q.size() == 0);
        chk("R2 readback", xctl_rdata, {m_mode, m_flags, e_full, e_empty});
        chk("R10 head", fifo_head, e_empty ? 8'h00 : m_q[0]);
        chk("R4 flags", {6'd0, fifo_full, fifo_empty}, {6'd0, e_full, e_empty});
        chk("R7 std enable", {7'd0, std_regs_en}, {7'd0, m_mode != 3'b011});
        chk("R8 bidir enable", {7'd0, bidir_en}, {7'd0, m_mode == 3'b001});
        chk("R9 cfg enable", {7'd0, cfg_regs_en}, {7'd0, m_mode == 3'b111});
    endtask

    // One cycle: inputs already set at a falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        xctl_wr = 0; data_fifo_wr = 0; test_fifo_wr = 0; test_fifo_rd = 0; drain_stb = 0;
    endtask

    task automatic set_mode(input logic [7:0] v);
        host_wdata = v; xctl_wr = 1; step();
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        step(); step();                                   // reset held low
        chk("R1 reset readback", xctl_rdata, 8'h01);
        chk("R1 reset head", fifo_head, 8'h00);
        rst_n = 1;
        step();
        // R2: flag bits stored, bits 1:0 of the write ignored
        set_mode(8'hFF);                                  // mode 111, reads 0xFD
        chk("R2 write ignores low bits", xctl_rdata, 8'hFD);
        chk("R9 cfg open", {7'd0, cfg_regs_en}, 8'h01);
        set_mode(8'h20);                                  // R8 byte mode
        chk("R8 byte bidir", {7'd0, bidir_en}, 8'h01);
        // R6: standard mode ignores every FIFO input
        set_mode(8'h00);
        host_wdata = 8'h5A; data_fifo_wr = 1; test_fifo_wr = 1; drain_stb = 1; step();
        chk("R6 std ignores push", {7'd0, fifo_empty}, 8'h01);
        // R6 R7: extended FIFO mode pushes data, ignores drain, hides registers
        set_mode(8'h60);
        chk("R7 std hidden", {7'd0, std_regs_en}, 8'h00);
        for (int i = 0; i < 3; i++) begin host_wdata = 8'hA0 + 8'(i); data_fifo_wr = 1; step(); end
        drain_stb = 1; step();
        chk("R6 drain ignored in 011", fifo_head, 8'hA0);
        test_fifo_rd = 1; step();                         // R3: test read ignored here
        chk("R3 test read ignored", fifo_head, 8'hA0);
        // R6: printer FIFO mode drains one per cycle in order (R10)
        set_mode(8'h40);
        drain_stb = 1; step();
        chk("R10 order after drain", fifo_head, 8'hA1);
        drain_stb = 1; step(); drain_stb = 1; step();
        drain_stb = 1; step();                            // R5: drain while empty
        chk("R5 empty pop dropped", xctl_rdata, 8'h41);
        // R3 R4 R5: test mode fills beyond depth
        set_mode(8'hC0);
        for (int i = 0; i < DEPTH + 2; i++) begin host_wdata = 8'(i * 7 + 1); test_fifo_wr = 1; step(); end
        chk("R4 full at depth", {7'd0, fifo_full}, 8'h01);
        chk("R5 overflow dropped head", fifo_head, 8'h01);
        // simultaneous push and pop while full: pop done, push dropped
        host_wdata = 8'hEE; test_fifo_wr = 1; test_fifo_rd = 1; step();
        chk("R5 full push+pop", {7'd0, fifo_full}, 8'h00);
        for (int i = 0; i < DEPTH + 1; i++) begin test_fifo_rd = 1; step(); end
        chk("R4 empty after reads", {7'd0, fifo_empty}, 8'h01);
        // push and pop while empty: push only
        host_wdata = 8'h3C; test_fifo_wr = 1; test_fifo_rd = 1; step();
        chk("R5 empty push+pop", fifo_head, 8'h3C);
        // every mode code decodes its enables
        for (int m = 0; m < 8; m++) set_mode(8'(m << 5));
        // reset mid-run returns to the reset state
        rst_n = 0; step(); rst_n = 1;
        chk("R1 second reset", xctl_rdata, 8'h01);
        step();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule